// File: doc/BRIEF.md
# Bidirectional GPIO Port

This block is a general-purpose I/O port of up to eight pins (the count is a parameter) placed between a simple register bus and a pad model. Software sets each pin's direction and output level through two registers. A third register sets the pad's pull-up request. A pin configured as input is read back through a two-flop synchronizer. On-chip peripherals can take a pin over: they assert an alternate-output enable and supply the level to drive, or they read the synchronized pin level as an alternate input.

Two elaboration parameters shape the port. The first is a mask of the pin positions that exist. The second is a mask that marks each existing pin as open-drain or push-pull. An open-drain pin only ever pulls its pad low. A push-pull pin drives both levels. Bus reads are combinational from the address. Bus writes take effect at the next rising clock edge.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted and after it is released, the data, direction and pull-up registers hold zero. With no alternate enable, every pad output enable is 0.
- R2: Direction bit 1 makes an existing pin an output: a push-pull pin raises pad_oe. Direction bit 0 makes it an input with pad_oe low. A write to address 1 changes pad_oe at the next cycle.
- R3: A write to the data register (address 0) updates the stored value even while the pin is an input. The stored value appears on the pad once the pin becomes an output.
- R4: A read of address 0 returns the stored data bit for output pins. For input pins it returns the pin level as seen through two synchronizer flops. A pad change therefore reads back after exactly two rising edges, not one.
- R5: For a pin that does not exist, the address-0 read bit is 1. Writes to its bit in every register are ignored, so address 1 and address 2 read 0 there. Its pad_oe, pad_out, pad_pu and alt_in stay 0.
- R6: A set alt_oe bit forces its existing pin to drive alt_out, whatever the direction bit holds.
- R7: An open-drain pin raises pad_oe only when its drive value is 0, and its pad_out is always 0. A push-pull pin drives pad_out equal to its drive value while pad_oe is 1, and 0 otherwise.
- R8: alt_in carries the synchronized pin level for an existing pin whose direction bit is 0, and 0 when the direction bit is 1.
- R9: pad_pu follows the pull-up register (address 2) bit for each existing pin.
- R10: Address 3 reads as 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 data, 1 direction, 2 pull-up, 3 unused |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Combinational read data for bus_addr |
| pad_in | input | WIDTH | Pin levels arriving from the pads |
| pad_oe | output | WIDTH | Per-pin output enable to the pads |
| pad_out | output | WIDTH | Per-pin output level to the pads |
| pad_pu | output | WIDTH | Per-pin pull-up request |
| alt_oe | input | WIDTH | Peripheral alternate-output enable per pin |
| alt_out | input | WIDTH | Peripheral alternate-output level per pin |
| alt_in | output | WIDTH | Synchronized pin level offered to peripherals |

## Verification
The bench builds the port with eight pins, with pin 6 absent (PIN_MASK 8'hBF) and pins 0 and 1 open-drain (OD_MASK 8'h03). These values put all three pin kinds in one run: missing, open-drain and push-pull. The absent pin exercises the read-as-one and write-ignore rules. The open-drain pins exercise the low-only drive under both register control and alternate control. The remaining push-pull pins cover direction, data and alternate override with both driven levels.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   localparam int unsigned GPIO_ADDR_W = 2;

   typedef enum logic [GPIO_ADDR_W-1:0] {
      REG_DATA = 2'd0,
      REG_DIR  = 2'd1,
      REG_PULL = 2'd2,
      REG_NONE = 2'd3
   } gpio_reg_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_port_pkg::*;
#(
   parameter int unsigned      WIDTH    = 8,
   parameter logic [WIDTH-1:0] PIN_MASK = '1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [GPIO_ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0]       wdata,
   output logic [WIDTH-1:0]       data_q,
   output logic [WIDTH-1:0]       dir_q,
   output logic [WIDTH-1:0]       pull_q
);

   logic [WIDTH-1:0] wmasked;
   assign wmasked = wdata & PIN_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '0;
         pull_q <= '0;
      end else if (wr_en) begin
         case (gpio_reg_e'(addr))
            REG_DATA: data_q <= wmasked;
            REG_DIR:  dir_q  <= wmasked;
            REG_PULL: pull_q <= wmasked;
            default:  ;
         endcase
      end
   end

endmodule

// File: rtl/gpio_pin.sv
module gpio_pin #(
   parameter bit PRESENT    = 1'b1,
   parameter bit OPEN_DRAIN = 1'b0
) (
   input  logic dir,
   input  logic data,
   input  logic pull,
   input  logic alt_oe,
   input  logic alt_out,
   input  logic sync_in,
   output logic pad_oe,
   output logic pad_out,
   output logic pad_pu,
   output logic alt_in,
   output logic rd_bit
);

   generate
      if (!PRESENT) begin : g_absent
         logic unused_absent;
         assign unused_absent = ^{dir, data, pull, alt_oe, alt_out, sync_in};
         assign pad_oe  = 1'b0;
         assign pad_out = 1'b0;
         assign pad_pu  = 1'b0;
         assign alt_in  = 1'b0;
         assign rd_bit  = 1'b1;
      end else begin : g_present
         logic drive_en;
         logic drive_val;
         assign drive_en  = alt_oe | dir;
         assign drive_val = alt_oe ? alt_out : data;
         assign pad_pu    = pull;
         assign alt_in    = ~dir & sync_in;
         assign rd_bit    = dir ? data : sync_in;
         if (OPEN_DRAIN) begin : g_od
            assign pad_oe  = drive_en & ~drive_val;
            assign pad_out = 1'b0;
         end else begin : g_pp
            assign pad_oe  = drive_en;
            assign pad_out = drive_en & drive_val;
         end
      end
   endgenerate

endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_port_pkg::*;
#(
   parameter int unsigned      WIDTH       = 8,
   parameter logic [WIDTH-1:0] PIN_MASK    = '1,
   parameter logic [WIDTH-1:0] OD_MASK     = '0,
   parameter int unsigned      SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_sel,
   input  logic                   bus_we,
   input  logic [GPIO_ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]       bus_wdata,
   output logic [WIDTH-1:0]       bus_rdata,
   input  logic [WIDTH-1:0]       pad_in,
   output logic [WIDTH-1:0]       pad_oe,
   output logic [WIDTH-1:0]       pad_out,
   output logic [WIDTH-1:0]       pad_pu,
   input  logic [WIDTH-1:0]       alt_oe,
   input  logic [WIDTH-1:0]       alt_out,
   output logic [WIDTH-1:0]       alt_in
);

   generate
      if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
         $error("gpio_port: WIDTH must lie in 1..32");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_port: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] data_q, dir_q, pull_q;
   logic [WIDTH-1:0] sync_q;
   logic [WIDTH-1:0] rd_bits;

   gpio_regs #(.WIDTH(WIDTH), .PIN_MASK(PIN_MASK)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bus_sel & bus_we),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .data_q (data_q),
      .dir_q  (dir_q),
      .pull_q (pull_q)
   );

   gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (sync_q)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      gpio_pin #(.PRESENT(PIN_MASK[i]), .OPEN_DRAIN(OD_MASK[i])) u_pin (
         .dir     (dir_q[i]),
         .data    (data_q[i]),
         .pull    (pull_q[i]),
         .alt_oe  (alt_oe[i]),
         .alt_out (alt_out[i]),
         .sync_in (sync_q[i]),
         .pad_oe  (pad_oe[i]),
         .pad_out (pad_out[i]),
         .pad_pu  (pad_pu[i]),
         .alt_in  (alt_in[i]),
         .rd_bit  (rd_bits[i])
      );
   end

   always_comb begin
      case (gpio_reg_e'(bus_addr))
         REG_DATA: bus_rdata = rd_bits;
         REG_DIR:  bus_rdata = dir_q;
         REG_PULL: bus_rdata = pull_q;
         default:  bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int unsigned      WIDTH    = 8,
   parameter logic [WIDTH-1:0] PIN_MASK = '1,
   parameter logic [WIDTH-1:0] OD_MASK  = '0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_sel,
   input logic             bus_we,
   input logic [1:0]       bus_addr,
   input logic [WIDTH-1:0] bus_wdata,
   input logic [WIDTH-1:0] bus_rdata,
   input logic [WIDTH-1:0] pad_oe,
   input logic [WIDTH-1:0] pad_out,
   input logic [WIDTH-1:0] alt_oe,
   input logic [WIDTH-1:0] alt_out
);

   localparam logic [WIDTH-1:0] PP_PINS = PIN_MASK & ~OD_MASK;
   localparam logic [WIDTH-1:0] OD_PINS = PIN_MASK & OD_MASK;

   // R5
   absent_pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe | pad_out) & ~PIN_MASK) == '0);

   // R5
   absent_read_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 2'd0) |-> ((bus_rdata | PIN_MASK) == {WIDTH{1'b1}}));

   // R6
   alt_forces_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (((alt_oe & PP_PINS) & ~pad_oe) == '0) &&
      (((pad_out ^ alt_out) & alt_oe & PP_PINS) == '0));

   // R7
   od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((alt_oe & alt_out & OD_PINS & pad_oe) == '0));

   // R2
   dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && bus_addr == 2'd1) |=>
      ((pad_oe & PP_PINS & ~alt_oe) == ($past(bus_wdata) & PP_PINS & ~alt_oe)));

endmodule

bind gpio_port gpio_port_chk #(
   .WIDTH(WIDTH), .PIN_MASK(PIN_MASK), .OD_MASK(OD_MASK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_oe    (pad_oe),
   .pad_out   (pad_out),
   .alt_oe    (alt_oe),
   .alt_out   (alt_out)
);

// File: tb/gpio_port_test.sv
module gpio_port_test;

   localparam int unsigned W  = 8;
   localparam logic [W-1:0] PM = 8'hBF;
   localparam logic [W-1:0] OD = 8'h03;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_sel = 1'b0, bus_we = 1'b0;
   logic [1:0]   bus_addr = 2'd0;
   logic [W-1:0] bus_wdata = '0, pad_in = '0, alt_oe = '0, alt_out = '0;
   logic [W-1:0] bus_rdata, pad_oe, pad_out, pad_pu, alt_in;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   gpio_port #(.WIDTH(W), .PIN_MASK(PM), .OD_MASK(OD), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
      .alt_oe(alt_oe), .alt_out(alt_out), .alt_in(alt_in)
   );

   // Bench model of the register state, built from the requirements
   logic [W-1:0] m_data, m_dir, m_pull, m_s1, m_s2;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_data <= '0; m_dir <= '0; m_pull <= '0; m_s1 <= '0; m_s2 <= '0;
      end else begin
         m_s1 <= pad_in;
         m_s2 <= m_s1;
         if (bus_sel && bus_we) begin
            case (bus_addr)
               2'd0: m_data <= bus_wdata & PM;
               2'd1: m_dir  <= bus_wdata & PM;
               2'd2: m_pull <= bus_wdata & PM;
               default: ;
            endcase
         end
      end
   end

   function automatic logic [W-1:0] f_drv_en();
      return (alt_oe | m_dir) & PM;
   endfunction

   function automatic logic [W-1:0] f_drv_val();
      return (alt_oe & alt_out) | (~alt_oe & m_data);
   endfunction

   function automatic logic [W-1:0] f_oe();
      return (f_drv_en() & ~OD) | (f_drv_en() & OD & ~f_drv_val());
   endfunction

   function automatic logic [W-1:0] f_out();
      return f_drv_en() & f_drv_val() & ~OD;
   endfunction

   function automatic logic [W-1:0] f_rd(input logic [1:0] a);
      case (a)
         2'd0: return (m_dir & m_data) | (~m_dir & m_s2 & PM) | ~PM;
         2'd1: return m_dir;
         2'd2: return m_pull;
         default: return '0;
      endcase
   endfunction

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_all();
      chk("R2 R6 R7 pad_oe", pad_oe, f_oe());
      chk("R7 pad_out", pad_out, f_out());
      chk("R9 pad_pu", pad_pu, m_pull);
      chk("R8 alt_in", alt_in, m_s2 & ~m_dir & PM);
      chk("R4 R10 bus_rdata", bus_rdata, f_rd(bus_addr));
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      // R1: state while in reset
      #5;
      chk("R1 rdata data in reset", bus_rdata, 8'h40);
      chk("R1 pad_oe in reset", pad_oe, 8'h00);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      bus_addr = 2'd1;
      #1 chk("R1 dir after reset", bus_rdata, 8'h00);
      bus_addr = 2'd2;
      #1 chk("R1 pull after reset", bus_rdata, 8'h00);

      // R4: two-edge synchronizer latency on an input pin
      bus_addr = 2'd0; pad_in = 8'hFF;
      @(negedge clk);
      chk("R4 one edge still old", bus_rdata, 8'h40);
      @(negedge clk);
      chk("R4 two edges new level", bus_rdata, 8'hFF);
      chk("R8 alt_in follows input", alt_in, 8'hBF);

      // R3: data written while input, then revealed by direction
      bus_write(2'd0, 8'hF0);
      bus_addr = 2'd0;
      #1 chk("R3 input pins still read pad", bus_rdata, 8'hFF);
      bus_write(2'd1, 8'hFF);
      #1 chk("R5 dir write of missing pin ignored", uut.bus_rdata, 8'hBF);
      bus_addr = 2'd0;
      #1 chk("R3 stored data now read", bus_rdata, 8'hF0 | 8'h40);
      chk("R3 push-pull pads drive data", pad_out, 8'hB0);
      chk("R7 open-drain pins pull low", pad_oe, 8'hBF);

      // R10: address 3 is inert
      bus_write(2'd3, 8'h5A);
      bus_addr = 2'd3;
      #1 chk("R10 addr3 reads zero", bus_rdata, 8'h00);
      bus_addr = 2'd1;
      #1 chk("R10 dir unchanged by addr3", bus_rdata, 8'hBF);

      // R6: alternate enable overrides input direction
      bus_write(2'd1, 8'h00);
      alt_oe = 8'hFF; alt_out = 8'h0F;
      #1 chk("R6 alt forces drive oe", pad_oe, 8'hBC);
      chk("R6 alt value on pad", pad_out, 8'h0C);
      alt_oe = '0; alt_out = '0;

      // R9 and R5: pull-up register
      bus_write(2'd2, 8'hFF);
      #1 chk("R9 R5 pull-up masked", pad_pu, 8'hBF);

      // Constrained random traffic checked against the model
      for (int n = 0; n < 3000; n++) begin
         @(negedge clk);
         check_all();
         bus_sel   = ($urandom_range(0, 2) != 0);
         bus_we    = $urandom_range(0, 1);
         bus_addr  = 2'($urandom_range(0, 3));
         bus_wdata = W'($urandom);
         pad_in    = W'($urandom);
         alt_oe    = ($urandom_range(0, 3) == 0) ? W'($urandom) : '0;
         alt_out   = W'($urandom);
      end
      @(negedge clk);
      check_all();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule